// File: doc/BRIEF.md
# Phase Error Sign-Change Crossover Timer

This block times how long a loop under test takes to correct an induced phase step. The moment it looks for is when the feedback clock first overtakes the reference clock, which is where overshoot begins. On every rising edge of the reference clock, a single flop sampling the feedback clock level acts as a bang-bang phase detector. A high sample means the feedback leads and a low sample means it lags.

The rising reference edge is brought into the fast clock domain through a synchronizer, and each synchronized edge raises a load pulse. Every load pulse shifts the detector result into a two-stage history in the fast domain. After a phase step is applied, the first synchronized reference rise starts the measurement. Each later rise adds one to a 10-bit count, so the resolution is one reference period.

When the history shows an older lag followed by a newer lead, the valid flag is set and the count freezes. If that never happens, the counter stops at its all-ones value and valid stays low. A synchronous clear puts the block back to idle before a test.

Top module: `crossTimer`

## Requirements
- R1: After reset, and one fast cycle after `clear` is high, `crossCount` is 0 and `crossValid` is 0.
- R2: Reference edges seen before any step is applied leave `crossCount` at 0 and `crossValid` at 0.
- R3: A `fbClk` level of 1 at a rising `refClk` edge is recorded as lead, and a level of 0 as lag.
- R4: The first rising `refClk` edge after `stepApplied` starts the measurement and loads the history without counting. After only that edge, `crossCount` is 0 and `crossValid` is 0, whatever the sample is.
- R5: While measuring, each further rising `refClk` edge raises `crossCount` by exactly one.
- R6: At the first edge whose sample is lead while the sample before it was lag, `crossValid` goes to 1. `crossCount` then equals the number of edges after the start edge, that edge included, and stays frozen while valid is high.
- R7: If 1023 edges after the start edge pass with no lag-to-lead change, `crossCount` stays at 1023 and `crossValid` stays 0. A change seen exactly at edge 1023 gives 1023 with valid 1.
- R8: After a measurement has ended, whether valid or saturated, further reference edges change neither output.
- R9: A `stepApplied` pulse after a measurement has ended clears both outputs to 0 and arms a new measurement.
- R10: When `clear` and `stepApplied` are high in the same cycle, `clear` wins: no measurement is armed and later edges are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastClk | input | 1 | Fast (oscillator) clock for the history, counter and control |
| refClk | input | 1 | Reference clock; its rising edge samples the feedback level |
| fbClk | input | 1 | Feedback clock, sampled as data by the bang-bang detector |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear to idle, fast domain |
| stepApplied | input | 1 | Pulse that arms a measurement, fast domain |
| crossCount | output | 10 | Reference cycles from the start edge to the sign change |
| crossValid | output | 1 | High once a lag-to-lead change has been seen |

## Verification
The bench sweeps every six-sample lead/lag prefix after the start edge. This catches a design that compares the history stages the wrong way round, and one that takes a lead on the start edge as a crossing. It also catches a design that counts the start edge, which would report one too many. The saturation run checks that the counter neither wraps to zero nor raises valid, and a crossing placed exactly on edge 1023 checks that the terminal edge is still judged as a crossing. Held results are probed with extra edges, a re-arm and a clear racing a step, to expose a design that keeps counting or lets the step win.

// File: rtl/crossTimerPkg.sv
package crossTimerPkg;
  typedef struct packed {
    logic clrAll;
    logic startRun;
    logic stepRun;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN,
    ST_DONE,
    ST_SAT
  } ctrlState_t;
endpackage

// File: rtl/crossTimerData.sv
import crossTimerPkg::*;

module crossTimerData #(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             fastClk,
  input  logic             refClk,
  input  logic             fbClk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  output logic             loadPulse,
  output logic             histFresh,
  output logic             pairLead,
  output logic             atMax,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                   bbSample;
  logic [SYNC_STAGES-1:0] refSync;
  logic                   refLast;
  logic [1:0]             hist;

  // bang-bang detector: feedback level at the reference rise
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) bbSample <= 1'b0;
    else       bbSample <= fbClk;
  end

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      refSync <= '0;
      refLast <= 1'b0;
    end else begin
      refSync <= {refSync[SYNC_STAGES-2:0], refClk};
      refLast <= refSync[SYNC_STAGES-1];
    end
  end

  assign loadPulse = refSync[SYNC_STAGES-1] & ~refLast;

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      hist      <= '0;
      count     <= '0;
      histFresh <= 1'b0;
    end else begin
      histFresh <= strobe.stepRun;
      if (strobe.clrAll) begin
        hist  <= '0;
        count <= '0;
      end else if (strobe.startRun) begin
        hist  <= {hist[0], bbSample};
      end else if (strobe.stepRun) begin
        hist  <= {hist[0], bbSample};
        if (count != CNT_MAX) count <= count + 1'b1;
      end
    end
  end

  // older stage lag, newer stage lead
  assign pairLead = ~hist[1] & hist[0];
  assign atMax    = (count == CNT_MAX);
endmodule

// File: rtl/crossTimerCtrl.sv
import crossTimerPkg::*;

module crossTimerCtrl (
  input  logic        fastClk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        stepApplied,
  input  logic        loadPulse,
  input  logic        histFresh,
  input  logic        pairLead,
  input  logic        atMax,
  output ctrlStrobe_t strobe,
  output logic        valid
);
  ctrlState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (clear) begin
      strobe.clrAll = 1'b1;
      stateNext     = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE, ST_DONE, ST_SAT: begin
          if (stepApplied) begin
            strobe.clrAll = 1'b1;
            stateNext     = ST_ARM;
          end
        end
        ST_ARM: begin
          if (loadPulse) begin
            strobe.startRun = 1'b1;
            stateNext       = ST_RUN;
          end
        end
        ST_RUN: begin
          if (loadPulse) begin
            strobe.stepRun = 1'b1;
          end else if (histFresh) begin
            if (pairLead)   stateNext = ST_DONE;
            else if (atMax) stateNext = ST_SAT;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign valid = (state == ST_DONE);
endmodule

// File: rtl/crossTimer.sv
import crossTimerPkg::*;

module crossTimer #(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             fastClk,
  input  logic             refClk,
  input  logic             fbClk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             stepApplied,
  output logic [CNT_W-1:0] crossCount,
  output logic             crossValid
);
  ctrlStrobe_t strobe;
  logic loadPulse, histFresh, pairLead, atMax;

  crossTimerData #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_data (
    .fastClk(fastClk), .refClk(refClk), .fbClk(fbClk), .rstN(rstN),
    .strobe(strobe), .loadPulse(loadPulse), .histFresh(histFresh),
    .pairLead(pairLead), .atMax(atMax), .count(crossCount)
  );

  crossTimerCtrl i_ctrl (
    .fastClk(fastClk), .rstN(rstN), .clear(clear), .stepApplied(stepApplied),
    .loadPulse(loadPulse), .histFresh(histFresh), .pairLead(pairLead),
    .atMax(atMax), .strobe(strobe), .valid(crossValid)
  );
endmodule

// File: rtl/crossTimerChecker.sv
module crossTimerChecker #(
  parameter int CNT_W = 10
) (
  input logic             fastClk,
  input logic             rstN,
  input logic             clear,
  input logic [CNT_W-1:0] crossCount,
  input logic             crossValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_COUNT_STEP: assert property (@(posedge fastClk) disable iff (!rstN)
    (crossCount != $past(crossCount)) |->
      (crossCount == CNT_W'($past(crossCount) + 1'b1) || crossCount == '0)); // R5

  AST_VALID_HOLD: assert property (@(posedge fastClk) disable iff (!rstN)
    (crossValid && $past(crossValid)) |-> $stable(crossCount)); // R6

  AST_VALID_NONZERO: assert property (@(posedge fastClk) disable iff (!rstN)
    $rose(crossValid) |-> (crossCount != '0)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge fastClk) disable iff (!rstN)
    ($past(crossCount) == CNT_MAX) |-> (crossCount == CNT_MAX || crossCount == '0)); // R7

  AST_CLEAR_EMPTY: assert property (@(posedge fastClk) disable iff (!rstN)
    clear |=> (crossCount == '0 && !crossValid)); // R1
endmodule

bind crossTimer crossTimerChecker #(.CNT_W(CNT_W)) i_chk (
  .fastClk(fastClk), .rstN(rstN), .clear(clear),
  .crossCount(crossCount), .crossValid(crossValid)
);

// File: tb/test_crossTimer.sv
module test_crossTimer;
  logic       fastClk = 1'b0;
  logic       refClk = 1'b0;
  logic       fbClk = 1'b0;
  logic       rstN = 1'b0;
  logic       clear = 1'b0;
  logic       stepApplied = 1'b0;
  logic [9:0] crossCount;
  logic       crossValid;

  int checks = 0;
  int errors = 0;

  crossTimer i_crossTimer (
    .fastClk(fastClk), .refClk(refClk), .fbClk(fbClk), .rstN(rstN),
    .clear(clear), .stepApplied(stepApplied),
    .crossCount(crossCount), .crossValid(crossValid)
  );

  always #4 fastClk = ~fastClk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic refCycle(input logic fb);
    @(negedge fastClk) fbClk = fb;
    @(negedge fastClk) refClk = 1'b1;
    repeat (4) @(negedge fastClk);
    refClk = 1'b0;
    repeat (2) @(negedge fastClk);
  endtask

  task automatic settle();
    repeat (8) @(negedge fastClk);
  endtask

  task automatic doClear();
    @(negedge fastClk) clear = 1'b1;
    @(negedge fastClk) clear = 1'b0;
  endtask

  task automatic doStep();
    @(negedge fastClk) stepApplied = 1'b1;
    @(negedge fastClk) stepApplied = 1'b0;
  endtask

  task automatic both(input string req, input int expCnt, input int expVal);
    chk(req, int'(crossCount), expCnt);
    chk(req, int'(crossValid), expVal);
  endtask

  initial begin
    repeat (190000) @(posedge fastClk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge fastClk);
    both("R1 reset", 0, 0);
    rstN = 1'b1;
    settle();

    // R2: edges before a step
    refCycle(1'b0); refCycle(1'b1); refCycle(1'b0); refCycle(1'b1);
    settle();
    both("R2 idle edges", 0, 0);

    // R4: lead on start edge is not a crossing
    doStep();
    refCycle(1'b1);
    settle();
    both("R4 start only", 0, 0);
    refCycle(1'b1); settle();
    both("R5 lead lead", 1, 0);
    refCycle(1'b0); settle();
    both("R5 then lag", 2, 0);
    refCycle(1'b1); settle();
    both("R6 lag to lead", 3, 1);

    // R8: held result
    refCycle(1'b0); refCycle(1'b1); settle();
    both("R8 hold after valid", 3, 1);

    // R9: re-arm
    doStep(); settle();
    both("R9 re-arm clears", 0, 0);
    refCycle(1'b0); refCycle(1'b1); settle();
    both("R9 new measurement", 1, 1);

    // R1: clear
    doClear(); settle();
    both("R1 clear", 0, 0);

    // R10: clear beats step
    @(negedge fastClk) begin clear = 1'b1; stepApplied = 1'b1; end
    @(negedge fastClk) begin clear = 1'b0; stepApplied = 1'b0; end
    refCycle(1'b0); refCycle(1'b1); refCycle(1'b0); refCycle(1'b1);
    settle();
    both("R10 clear priority", 0, 0);

    // R3 R5 R6: every six-sample prefix, then lag, lead
    for (int p = 0; p < 64; p++) begin
      logic [7:0] s;
      int k;
      s = {2'b10, p[5:0]};
      k = 0;
      for (int i = 1; i < 8; i++)
        if (k == 0 && !s[i-1] && s[i]) k = i;
      doClear();
      doStep();
      for (int i = 0; i <= k; i++) refCycle(s[i]);
      settle();
      both($sformatf("R3 R6 sweep pattern %0d", p), k, 1);
    end

    // R7: saturation with all lead
    doClear(); doStep();
    for (int i = 0; i < 1030; i++) refCycle(1'b1);
    settle();
    both("R7 saturate", 1023, 0);
    refCycle(1'b0); refCycle(1'b1); settle();
    both("R8 hold after saturate", 1023, 0);

    // R7: crossing on the last edge
    doClear(); doStep();
    for (int i = 0; i < 1023; i++) refCycle(1'b0);
    refCycle(1'b1);
    settle();
    both("R7 crossing at 1023", 1023, 1);

    // R6: crossing one edge earlier
    doClear(); doStep();
    for (int i = 0; i < 1022; i++) refCycle(1'b0);
    refCycle(1'b1);
    settle();
    both("R6 crossing at 1022", 1022, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule